// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block is an 8-bit up-counting timer that serves either as a watchdog or as a periodic interval source. A prescaler divides the core clock by one of eight powers of two, from 32 to 4096, and feeds the counter one count pulse per period. When the counter rolls over from its top value to zero, the block records an overflow flag that belongs to the current mode. In watchdog mode it also issues a single-cycle reset request. In interval mode it raises an interrupt request that stays high until software clears the flag.

Software reaches the block through a small write/read port with three registers, at addresses 0, 1 and 2. The counter value (address 0) can be read and loaded. The control register (address 1) holds the run bit (bit 7), the mode bit (bit 6, 1 = watchdog, 0 = interval) and the 3-bit clock-select code (bits 2:0). The status register (address 2) holds the watchdog flag (bit 1) and the interval flag (bit 0). Reads come from `rdata`, which is combinational in `addr`. A write takes effect on the rising clock edge where `wr_en` is high.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the counter, control and status registers all read 0x00: the timer is stopped, in interval mode, with clock-select 000. `rst_req` and `irq` are low.
- R2: While the run bit is set, the counter advances by one on every 2^(5+code)-th clock edge, counted from the edge that set the run bit. While the run bit is clear, the counter holds its value.
- R3: Clock-select codes 0 to 7 pick divide ratios 32, 64, 128, 256, 512, 1024, 2048 and 4096 in that order. The code reads back in control bits 2:0.
- R4: A control write lands in bits 2:0 only when the run bit is already clear. The same write always updates the run bit (7) and the mode bit (6).
- R5: A count pulse at 0xFF wraps the counter to 0x00, which is the overflow event. Counting then continues from 0x00.
- R6: An overflow in watchdog mode sets status bit 1 and raises `rst_req` for exactly one cycle, in the cycle after the wrapping edge. It never sets status bit 0.
- R7: An overflow in interval mode sets status bit 0 and never sets status bit 1. `irq` is high exactly while status bit 0 is set, and `rst_req` stays low.
- R8: Writing the status register clears each flag whose written bit is 0. Flags whose written bit is 1 are left unchanged.
- R9: An overflow on the same edge as a write that would clear the flag leaves that flag set.
- R10: A write to the counter loads the written value. If a count pulse falls on the same edge, the load wins and no overflow is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 counter, 1 control, 2 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| rst_req | output | 1 | One-cycle reset request on a watchdog overflow |
| irq | output | 1 | Interrupt request, follows the interval flag |

## Verification
The situations hardest to reach from the ports are the same-edge collisions. One is an overflow landing on the edge of a flag-clear write. The other is a count pulse landing on a counter load, including a load over 0xFF that must suppress the overflow. The stimulus reaches both by counting clock edges from the write that sets the run bit, since the prescaler restarts from zero at that edge. The colliding write is then placed exactly on the 32nd edge. The slow ratios would take up to a million cycles to overflow from zero, so the sweeps over all eight codes preload 0xFE or 0xFF. This brings each mode's overflow within one or two prescaler periods.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int CNT_W    = 8;
  localparam int SEL_W    = 3;
  localparam int PRE_BASE = 5;
  localparam int ADDR_W   = 2;
  localparam int N_FLAG   = 2;

  localparam int FLAG_IV  = 0;
  localparam int FLAG_WD  = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_COUNT = 2'd0,
    REG_CTRL  = 2'd1,
    REG_STAT  = 2'd2,
    REG_NONE  = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_BASE = wdt_pkg::PRE_BASE,
  parameter int SEL_W    = wdt_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int PRE_W = PRE_BASE + (1 << SEL_W) - 1;

  // Low-bit mask for the selected tap: PRE_BASE+sel ones.
  function automatic logic [PRE_W-1:0] tap_mask(input logic [SEL_W-1:0] s);
    return {PRE_W{1'b1}} >> (~s);
  endfunction

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;

  assign mask = tap_mask(sel);
  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= '0;
    else if (!run)  div_q <= '0;
    else            div_q <= div_q + PRE_W'(1);
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = wdt_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);

  // Increment with carry out; the carry marks the wrap to zero.
  function automatic logic [CNT_W:0] bump(input logic [CNT_W-1:0] v);
    return {1'b0, v} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  logic [CNT_W-1:0] count_q;
  logic [CNT_W:0]   nxt;

  assign nxt   = bump(count_q);
  assign ovf   = tick && !load && nxt[CNT_W];
  assign count = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (load)  count_q <= load_val;
    else if (tick)  count_q <= nxt[CNT_W-1:0];
  end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int SEL_W  = wdt_pkg::SEL_W,
  parameter int N_FLAG = wdt_pkg::N_FLAG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              wr_run,
  input  logic              wr_wd,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              stat_wr,
  input  logic [N_FLAG-1:0] wr_keep,
  input  logic              ovf,
  output logic              run,
  output logic              wd_mode,
  output logic [SEL_W-1:0]  sel,
  output logic [N_FLAG-1:0] flags,
  output logic              rst_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      wd_mode <= 1'b0;
      sel     <= '0;
    end else if (ctrl_wr) begin
      run     <= wr_run;
      wd_mode <= wr_wd;
      if (!run) sel <= wr_sel;
    end
  end

  // One sticky flag per mode; a set beats a clear on the same edge.
  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    logic hit;
    assign hit = ovf && ((g == wdt_pkg::FLAG_WD) ? wd_mode : !wd_mode);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     flags[g] <= 1'b0;
      else if (hit)                   flags[g] <= 1'b1;
      else if (stat_wr && !wr_keep[g]) flags[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= ovf && wd_mode;
  end

endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer #(
  parameter int CNT_W    = wdt_pkg::CNT_W,
  parameter int SEL_W    = wdt_pkg::SEL_W,
  parameter int PRE_BASE = wdt_pkg::PRE_BASE,
  parameter int ADDR_W   = wdt_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              rst_req,
  output logic              irq
);

  localparam int N_FLAG   = wdt_pkg::N_FLAG;
  localparam int RUN_BIT  = CNT_W - 1;
  localparam int MODE_BIT = CNT_W - 2;

  // Named internal events, also used by the bound checker.
  logic              count_wr;
  logic              ctrl_wr;
  logic              stat_wr;
  logic              tick;
  logic              ovf;
  logic              run;
  logic              wd_mode;
  logic [SEL_W-1:0]  sel;
  logic [CNT_W-1:0]  count;
  logic [N_FLAG-1:0] flags;

  assign count_wr = wr_en && (addr == wdt_pkg::REG_COUNT);
  assign ctrl_wr  = wr_en && (addr == wdt_pkg::REG_CTRL);
  assign stat_wr  = wr_en && (addr == wdt_pkg::REG_STAT);

  wdt_prescaler #(.PRE_BASE(PRE_BASE), .SEL_W(SEL_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (sel),
    .tick (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .load    (count_wr),
    .load_val(wdata),
    .count   (count),
    .ovf     (ovf)
  );

  wdt_regs #(.SEL_W(SEL_W), .N_FLAG(N_FLAG)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_wr(ctrl_wr),
    .wr_run (wdata[RUN_BIT]),
    .wr_wd  (wdata[MODE_BIT]),
    .wr_sel (wdata[SEL_W-1:0]),
    .stat_wr(stat_wr),
    .wr_keep(wdata[N_FLAG-1:0]),
    .ovf    (ovf),
    .run    (run),
    .wd_mode(wd_mode),
    .sel    (sel),
    .flags  (flags),
    .rst_req(rst_req)
  );

  assign irq = flags[wdt_pkg::FLAG_IV];

  always_comb begin
    rdata = '0;
    case (addr)
      wdt_pkg::REG_COUNT: rdata = count;
      wdt_pkg::REG_CTRL: begin
        rdata[RUN_BIT]     = run;
        rdata[MODE_BIT]    = wd_mode;
        rdata[SEL_W-1:0]   = sel;
      end
      wdt_pkg::REG_STAT:  rdata[N_FLAG-1:0] = flags;
      default:            rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W  = wdt_pkg::CNT_W,
  parameter int SEL_W  = wdt_pkg::SEL_W,
  parameter int N_FLAG = wdt_pkg::N_FLAG
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              wd_mode,
  input logic [SEL_W-1:0]  sel,
  input logic [CNT_W-1:0]  count,
  input logic              tick,
  input logic              ovf,
  input logic              count_wr,
  input logic [CNT_W-1:0]  wdata,
  input logic [N_FLAG-1:0] flags,
  input logic              rst_req
);

  localparam int IV = wdt_pkg::FLAG_IV;
  localparam int WD = wdt_pkg::FLAG_WD;

  p_no_tick_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !count_wr) |=> count == $past(count) + {{(CNT_W-1){1'b0}}, 1'b1});

  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(sel));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> count == '0);

  p_wd_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && wd_mode) |=> (flags[WD] && rst_req));

  p_wd_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[WD]) |-> $past(ovf && wd_mode));

  p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_iv_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !wd_mode) |=> (flags[IV] && !rst_req));

  p_iv_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[IV]) |-> $past(ovf && !wd_mode));

  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count_wr |=> count == $past(wdata));

endmodule

bind dual_mode_timer wdt_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .wd_mode (wd_mode),
  .sel     (sel),
  .count   (count),
  .tick    (tick),
  .ovf     (ovf),
  .count_wr(count_wr),
  .wdata   (wdata),
  .flags   (flags),
  .rst_req (rst_req)
);

// File: tb/sim_dual_mode_timer.sv
`timescale 1ns/1ps
module sim_dual_mode_timer;

  localparam logic [1:0] A_CNT = 2'd0;
  localparam logic [1:0] A_CTL = 2'd1;
  localparam logic [1:0] A_STA = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       rst_req;
  logic       irq;
  logic       done = 1'b0;
  int         vecs = 0;
  int         errs = 0;

  always #2 clk = ~clk;

  dual_mode_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_req(rst_req), .irq(irq)
  );

  function automatic logic [7:0] ctl(input logic r, input logic w, input int s);
    return {r, w, 3'b000, s[2:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : g_watch
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        vecs++; errs++;
        $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
      end
    end
  end

  initial begin : g_main
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_reg("R1 count", A_CNT, 8'h00);
    chk_reg("R1 ctrl", A_CTL, 8'h00);
    chk_reg("R1 status", A_STA, 8'h00);
    check("R1 rst_req", rst_req, 0);
    check("R1 irq", irq, 0);
    wait_edges(100);
    chk_reg("R2 stopped hold after reset", A_CNT, 8'h00);

    // R2/R3 rate sweep over all codes
    for (int s = 0; s < 8; s++) begin
      d = 32 << s;
      wr(A_CTL, ctl(0, 0, s));
      wr(A_CNT, 8'h00);
      wr(A_CTL, ctl(1, 0, s));
      wait_edges(d - 1);
      chk_reg("R2 before first pulse", A_CNT, 8'h00);
      wait_edges(1);
      chk_reg("R3 first pulse", A_CNT, 8'h01);
      wait_edges(2 * d);
      chk_reg("R3 third pulse", A_CNT, 8'h03);
      chk_reg("R3 code readback", A_CTL, ctl(1, 0, s));
      wr(A_CTL, ctl(0, 0, s));
      wait_edges(d + 5);
      chk_reg("R2 hold while stopped", A_CNT, 8'h03);
    end

    // R4 code write ignored while running
    wr(A_CTL, ctl(0, 0, 0));
    wr(A_CNT, 8'h00);
    wr(A_CTL, ctl(1, 0, 0));          // edge 0
    wr(A_CTL, ctl(1, 0, 5));          // edge 1
    chk_reg("R4 code kept while running", A_CTL, ctl(1, 0, 0));
    wait_edges(63);                   // edge 64
    chk_reg("R4 rate unchanged", A_CNT, 8'h02);
    wr(A_CTL, ctl(1, 1, 3));
    chk_reg("R4 mode written while running", A_CTL, ctl(1, 1, 0));
    wr(A_CTL, ctl(0, 0, 0));
    wr(A_CTL, ctl(0, 0, 6));
    chk_reg("R4 code honoured when stopped", A_CTL, ctl(0, 0, 6));

    // R5/R6 watchdog overflow, every code
    for (int s = 0; s < 8; s++) begin
      d = 32 << s;
      wr(A_CTL, ctl(0, 1, s));
      wr(A_CNT, 8'hFE);
      wr(A_CTL, ctl(1, 1, s));
      wait_edges(2 * d - 1);
      check("R6 no request before wrap", rst_req, 0);
      chk_reg("R6 no flag before wrap", A_STA, 8'h00);
      wait_edges(1);
      check("R6 request pulse", rst_req, 1);
      chk_reg("R6 watchdog flag only", A_STA, 8'h02);
      chk_reg("R5 wrap to zero", A_CNT, 8'h00);
      check("R7 no irq in watchdog mode", irq, 0);
      wait_edges(1);
      check("R6 request one cycle", rst_req, 0);
      wait_edges(d - 1);
      chk_reg("R5 counting resumes", A_CNT, 8'h01);
      wr(A_CTL, ctl(0, 1, s));
      wr(A_STA, 8'h03);
      chk_reg("R8 write of ones keeps flag", A_STA, 8'h02);
      wr(A_STA, 8'h01);
      chk_reg("R8 zero clears watchdog flag", A_STA, 8'h00);
    end

    // R7 interval overflow, every code
    for (int s = 0; s < 8; s++) begin
      d = 32 << s;
      wr(A_CTL, ctl(0, 0, s));
      wr(A_CNT, 8'hFF);
      wr(A_CTL, ctl(1, 0, s));
      wait_edges(d - 1);
      check("R7 irq low before wrap", irq, 0);
      wait_edges(1);
      chk_reg("R7 interval flag only", A_STA, 8'h01);
      check("R7 irq raised", irq, 1);
      check("R7 no reset request", rst_req, 0);
      wait_edges(50);
      check("R7 irq held", irq, 1);
      wr(A_CTL, ctl(0, 0, s));
      wr(A_STA, 8'h02);
      chk_reg("R8 zero clears interval flag", A_STA, 8'h00);
      check("R8 irq drops with flag", irq, 0);
    end

    // R9 overflow beats a same-edge clear, both modes
    for (int m = 0; m < 2; m++) begin
      wr(A_CTL, ctl(0, m[0], 0));
      wr(A_CNT, 8'hFF);
      wr(A_CTL, ctl(1, m[0], 0));     // edge 0
      wait_edges(31);
      wr(A_STA, 8'h00);               // edge 32, overflow
      chk_reg("R9 set wins over clear", A_STA, m[0] ? 8'h02 : 8'h01);
      wr(A_CTL, ctl(0, 0, 0));
      wr(A_STA, 8'h00);
      chk_reg("R9 cleared afterwards", A_STA, 8'h00);
    end

    // R10 load on a count-pulse edge
    wr(A_CTL, ctl(0, 0, 0));
    wr(A_CNT, 8'h10);
    chk_reg("R10 plain load", A_CNT, 8'h10);
    wr(A_CTL, ctl(1, 0, 0));          // edge 0
    wait_edges(31);
    wr(A_CNT, 8'h40);                 // edge 32
    chk_reg("R10 load beats pulse", A_CNT, 8'h40);
    wait_edges(31);                   // edge 63
    chk_reg("R10 no pulse yet", A_CNT, 8'h40);
    wait_edges(1);                    // edge 64
    chk_reg("R10 next pulse", A_CNT, 8'h41);
    wait_edges(31);
    wr(A_CNT, 8'hFF);                 // edge 96
    wait_edges(31);
    wr(A_CNT, 8'h80);                 // edge 128, would wrap
    chk_reg("R10 load over FF", A_CNT, 8'h80);
    chk_reg("R10 no overflow recorded", A_STA, 8'h00);
    check("R10 irq stays low", irq, 0);
    wr(A_CTL, ctl(0, 0, 0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule